// File: doc/BRIEF.md
# Per-Set Round-Robin Victim Selector with Way Locking

This block picks the way to evict in a 32-set, 32-way set-associative cache. Each set holds two pieces of state: a lock count N and a round-robin pointer. The lowest N ways of a set are locked. They can act as local SRAM and are never offered as a victim. The pointer cycles only over ways N to 31.

The victim output always shows the pointer of the set addressed by the set index. It is a combinational read, so a fill controller can read the victim in the same cycle that it raises the allocate strobe. The allocate strobe then moves that set's pointer on.

A lock command writes a new lock count for the addressed set, in the range 0 to 28. If the new count lies past the pointer, the pointer is pulled up to the new count. An unlock command clears the lock count of the addressed set. A lock command asking for more than 28 ways is refused and raises an error pulse.

Top module: `rr_victim_select`

## Requirements
- R1: After reset every set has lock count 0 and pointer 0, so `victim_way` reads 0 for every set and `lock_err` is 0.
- R2: `victim_way` equals the pointer of the set selected by `set_idx` in the same cycle, with no clock delay. It is never below that set's lock count.
- R3: An accepted allocate (`alloc` high while `lock_req` and `unlock_req` are both low) moves the addressed set's pointer from p to p+1 when p < 31. The new value is visible after the next rising clock edge.
- R4: An accepted allocate when the pointer is 31 wraps the pointer to the set's lock count N.
- R5: `lock_req` with `lock_ways` ≤ 28 sets the addressed set's lock count to `lock_ways`. If the pointer is below the new count, the pointer becomes the new count; otherwise the pointer is unchanged.
- R6: `lock_req` with `lock_ways` > 28 changes no state. `lock_err` is high for exactly the one cycle after that edge.
- R7: `unlock_req` (with `lock_req` low) sets the addressed set's lock count to 0 and leaves its pointer unchanged. A later wrap therefore returns to way 0.
- R8: A command changes only the set addressed by `set_idx`. All other sets keep their lock counts and pointers.
- R9: Priority within one cycle is `lock_req`, then `unlock_req`, then `alloc`. A lower-priority command asserted together with a higher one is dropped. A refused lock also drops `unlock_req` and `alloc`.
- R10: `lock_err` is 0 in every cycle that does not follow a refused lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| set_idx | input | 5 | Set addressed by the read and by any command |
| alloc | input | 1 | Advance the addressed set's pointer |
| lock_req | input | 1 | Write a new lock count for the addressed set |
| unlock_req | input | 1 | Clear the lock count of the addressed set |
| lock_ways | input | 6 | Requested lock count for `lock_req` |
| victim_way | output | 5 | Victim way of the addressed set (combinational) |
| lock_err | output | 1 | One-cycle pulse after a refused lock request |

## Verification
`victim_way` is a combinational read of the addressed set, so the bench checks it about 1 ns after it drives `set_idx`, before any clock edge. The effect of a command on the pointer is due after the next rising edge. The bench checks it at the following falling edge, or on the next read of that set.

`lock_err` is registered and belongs to the single cycle after the refused request. It is sampled at the falling edge after that rising edge, and sampled again one cycle later to confirm the pulse has ended. Full sweeps of every lock count from 0 to 32, plus a random command mix checked against a per-set arithmetic model across all 32 sets, cover the wrap, pull-up, priority and isolation cases.

// File: rtl/rr_victim_select.sv
module rr_victim_select #(
  parameter int SETS     = 32,
  parameter int WAYS     = 32,
  parameter int MAX_LOCK = 28,
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS),
  localparam int CW = $clog2(WAYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_idx,
  input  logic          alloc,
  input  logic          lock_req,
  input  logic          unlock_req,
  input  logic [CW-1:0] lock_ways,
  output logic [WW-1:0] victim_way,
  output logic          lock_err
);

  logic [CW-1:0] lock_q [SETS];
  logic [WW-1:0] ptr_q  [SETS];

  logic [WW-1:0] cur_ptr;
  logic [CW-1:0] cur_lock;
  logic          bad_lock;
  logic          at_last;
  logic [WW-1:0] adv_ptr;

  assign cur_ptr    = ptr_q[set_idx];
  assign cur_lock   = lock_q[set_idx];
  assign victim_way = cur_ptr;
  assign bad_lock   = lock_req && (lock_ways > CW'(MAX_LOCK));
  assign at_last    = (cur_ptr == WW'(WAYS - 1));
  assign adv_ptr    = at_last ? WW'(cur_lock) : cur_ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        lock_q[s] <= '0;
        ptr_q[s]  <= '0;
      end
      lock_err <= 1'b0;
    end else begin
      lock_err <= bad_lock;
      if (lock_req) begin
        if (!bad_lock) begin
          lock_q[set_idx] <= lock_ways;
          if (CW'(cur_ptr) < lock_ways) ptr_q[set_idx] <= WW'(lock_ways);
        end
      end else if (unlock_req) begin
        lock_q[set_idx] <= '0;
      end else if (alloc) begin
        ptr_q[set_idx] <= adv_ptr;
      end
    end
  end

  // R2: the offered victim is never a locked way
  a_r2_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(victim_way) >= cur_lock);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !lock_req && !unlock_req && !at_last)
    |=> ptr_q[$past(set_idx)] == $past(cur_ptr) + 1'b1);

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !lock_req && !unlock_req && at_last)
    |=> ptr_q[$past(set_idx)] == WW'($past(cur_lock)));

  a_r5_lock_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_req && !bad_lock)
    |=> (lock_q[$past(set_idx)] == $past(lock_ways)) &&
        (CW'(ptr_q[$past(set_idx)]) >= $past(lock_ways)));

  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bad_lock |=> lock_err);

  a_r6_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    bad_lock |=> (lock_q[$past(set_idx)] == $past(cur_lock)) &&
                 (ptr_q[$past(set_idx)] == $past(cur_ptr)));

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> $past(bad_lock));

  a_r7_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_req && !lock_req)
    |=> (lock_q[$past(set_idx)] == '0) && (ptr_q[$past(set_idx)] == $past(cur_ptr)));

endmodule

// File: tb/test_rr_victim_select.sv
module test_rr_victim_select;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 32;
  localparam int NWAYS = 32;
  localparam int MAXL  = 28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] set_idx = '0;
  logic       alloc = 1'b0, lock_req = 1'b0, unlock_req = 1'b0;
  logic [5:0] lock_ways = '0;
  logic [4:0] victim_way;
  logic       lock_err;

  int errors = 0;
  int checks = 0;
  int exp_n [NSETS];
  int exp_p [NSETS];
  int exp_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_victim_select i_rr_victim_select (
    .clk, .rst_n, .set_idx, .alloc, .lock_req, .unlock_req,
    .lock_ways, .victim_way, .lock_err
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // read the victim of a set without issuing a command
  task automatic peek(input int s, input string req);
    set_idx = 5'(s);
    #1;
    chk(victim_way == 5'(exp_p[s]), req, victim_way, exp_p[s]);
  endtask

  // one cycle: drive at falling edge, check victim, clock, check error flag
  task automatic step(input int s, input bit a, input bit l, input bit u, input int w);
    set_idx = 5'(s); alloc = a; lock_req = l; unlock_req = u; lock_ways = 6'(w);
    #1;
    chk(victim_way == 5'(exp_p[s]), "R2 victim", victim_way, exp_p[s]);
    @(posedge clk);
    exp_err = 0;
    if (l) begin
      if (w > MAXL) exp_err = 1;
      else begin
        exp_n[s] = w;
        if (exp_p[s] < w) exp_p[s] = w;
      end
    end else if (u) exp_n[s] = 0;
    else if (a) exp_p[s] = (exp_p[s] == NWAYS - 1) ? exp_n[s] : exp_p[s] + 1;
    @(negedge clk);
    alloc = 0; lock_req = 0; unlock_req = 0;
    chk(lock_err == exp_err[0], exp_err ? "R6 err pulse" : "R10 err low", lock_err, exp_err);
  endtask

  task automatic sweep_all(input string req);
    for (int s = 0; s < NSETS; s++) peek(s, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSETS; s++) begin exp_n[s] = 0; exp_p[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    sweep_all("R1 reset victim");
    chk(lock_err == 1'b0, "R1 reset err", lock_err, 0);

    // R3/R4 plain rotation and wrap with no locks
    for (int i = 0; i < 40; i++) step(3, 1, 0, 0, 0);
    peek(3, "R4 wrap to 0");
    sweep_all("R8 other sets untouched");

    // R5/R4/R6 exhaustive lock counts on set 7
    for (int w = 0; w <= 32; w++) begin
      step(7, 0, 1, 0, w);
      if (w > MAXL) begin
        step(7, 0, 0, 0, 0);
        chk(lock_err == 1'b0, "R6 pulse one cycle", lock_err, 0);
      end
      peek(7, "R5 pointer after lock");
      for (int i = 0; i < NWAYS + 2; i++) step(7, 1, 0, 0, 0);
      peek(7, "R4 wrap to lock count");
    end
    step(7, 0, 1, 0, 63);
    chk(exp_n[7] == MAXL, "R6 state kept", exp_n[7], MAXL);

    // R5 lowering the lock below the pointer leaves the pointer
    step(9, 0, 1, 0, 10);
    for (int i = 0; i < 8; i++) step(9, 1, 0, 0, 0);
    step(9, 0, 1, 0, 4);
    peek(9, "R5 pointer kept");

    // R7 unlock keeps pointer, then wrap reaches way 0
    step(9, 0, 0, 1, 0);
    peek(9, "R7 pointer kept on unlock");
    for (int i = 0; i < NWAYS; i++) step(9, 1, 0, 0, 0);
    peek(9, "R7 wrap reaches 0");

    // R9 priority cases
    step(11, 1, 1, 1, 20);
    peek(11, "R9 lock wins");
    step(11, 1, 0, 1, 0);
    peek(11, "R9 unlock drops alloc");
    step(11, 1, 1, 1, 30);
    peek(11, "R9 refused lock drops rest");

    // R8 random mix across all sets
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 19);
      int s = $urandom_range(0, NSETS - 1);
      if (r < 14)      step(s, 1, 0, 0, 0);
      else if (r < 17) step(s, $urandom_range(0, 1), 1, $urandom_range(0, 1), $urandom_range(0, 33));
      else             step(s, $urandom_range(0, 1), 0, 1, 0);
    end
    sweep_all("R8 per-set isolation");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule